// File: doc/BRIEF.md
# PHY Management Register Model

This block models the management side of an Ethernet PHY as seen through a two-register host window. Software writes a command word naming a PHY address, a register number and a direction. On the following clock the block carries out that access against a small internal PHY register set. A read lands in the shared data register. A write takes its value from the data register.

The PHY register set has these members:
- a writable control register with a self-clearing reset bit;
- a status register whose link bit tracks a live input;
- an advertisement register that can be read and written;
- two identifier constants;
- a fixed link-partner ability word.

Commands aimed at any other PHY address are stored but do nothing. The block has no serial management pins and does no real autonegotiation.

Top module: `phy_mgmt_model`

## Requirements
- R1: A bus write to the command window (bus_addr=0) stores the word with bit 0 (busy) cleared, and it reads back that way. Command fields: PHY address in bits 15:12, register number in bits 7:4, write flag in bit 1 (1 = write PHY register).
- R2: A command whose PHY address differs from the PHY_ADDR parameter changes neither the data register nor any PHY register.
- R3: A command executes on the clock edge after the edge that stores it. A read of the data window (bus_addr=1) in the cycle after that edge returns the result.
- R4: After reset the control register (number 0) reads 0x3100.
- R5: Writing control with bit 15 clear stores the data value with bits 15 and 9 forced to zero.
- R6: Writing control with bit 15 set restores control to 0x3100 and advertisement to 0x0000.
- R7: The status register (number 1) reads 0xFE28 OR'd with the link input in bit 2. The link bit follows link_up in the same cycle.
- R8: Registers 2 and 3 read 0x0044 and 0x1400. Writes to them are ignored.
- R9: The advertisement register (number 4) is read/write and resets to 0x0000.
- R10: The partner register (number 5) reads 0x0DE0. Writes to it are ignored.
- R11: Reading any register number above 5 returns 0x0000. Writing such a number has no effect.
- R12: A bus write to the data window stores the value. If a read command executes on the same edge, the read result wins.
- R13: After reset both windows read 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | Window select: 0 command, 1 data |
| bus_wr | input | 1 | Write strobe for the selected window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Contents of the selected window |
| link_up | input | 1 | Live link state shown in status bit 2 |

## Verification
Two things can coincide on one edge. First, a host write to the data window can land on the edge where a previously stored read command executes. The bench provokes this by issuing the data write directly after the command write, and it expects the PHY register value to win. Second, the link input can toggle while a status read is executing, or while a control reset is being applied. The bench flips link_up on those cycles and judges the status value against the level present at the executing edge. A behavioural model updated every clock compares the selected window on each cycle.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int DW      = 16;
  localparam int RNW     = 4;
  localparam int PAW     = 4;
  localparam int PHY_LSB = 12;
  localparam int REG_LSB = 4;
  localparam int WR_BIT  = 1;

  localparam logic [DW-1:0] CTRL_DEF     = 16'h3100;
  localparam logic [DW-1:0] CTRL_KEEP    = 16'h7DFF;
  localparam logic [DW-1:0] STAT_FIXED   = 16'hFE28;
  localparam int            STAT_LINK    = 2;
  localparam int            CTRL_RST_BIT = 15;
  localparam logic [DW-1:0] ID_HI_VAL    = 16'h0044;
  localparam logic [DW-1:0] ID_LO_VAL    = 16'h1400;
  localparam logic [DW-1:0] PARTNER_VAL  = 16'h0DE0;

  typedef enum logic [RNW-1:0] {
    PR_CTRL    = 4'd0,
    PR_STAT    = 4'd1,
    PR_ID_HI   = 4'd2,
    PR_ID_LO   = 4'd3,
    PR_ADV     = 4'd4,
    PR_PARTNER = 4'd5
  } phy_reg_e;

  typedef struct packed {
    logic [PAW-1:0] phy;
    logic [RNW-1:0] regn;
    logic           wr;
  } mgmt_cmd_t;
endpackage

// File: rtl/phy_cmd_decode.sv
module phy_cmd_decode
  import phy_mgmt_pkg::*;
#(
  parameter logic [PAW-1:0] PHY_ADDR = '0
) (
  input  logic [DW-1:0] cmd_word,
  output mgmt_cmd_t     fields,
  output logic          hit
);
  always_comb begin
    fields.phy  = cmd_word[PHY_LSB +: PAW];
    fields.regn = cmd_word[REG_LSB +: RNW];
    fields.wr   = cmd_word[WR_BIT];
    hit         = (fields.phy == PHY_ADDR);
  end
endmodule

// File: rtl/phy_regfile.sv
module phy_regfile
  import phy_mgmt_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           exec_wr,
  input  logic [RNW-1:0] regn,
  input  logic [DW-1:0]  wdata,
  input  logic           link_up,
  output logic [DW-1:0]  rd_val
);
  logic [DW-1:0] ctrl_q, ctrl_d, adv_q, adv_d;
  logic          ctrl_en, adv_en;

  always_comb begin
    ctrl_en = 1'b0;
    adv_en  = 1'b0;
    ctrl_d  = ctrl_q;
    adv_d   = adv_q;
    if (exec_wr) begin
      if (regn == PR_CTRL) begin
        ctrl_en = 1'b1;
        if (wdata[CTRL_RST_BIT]) begin
          ctrl_d = CTRL_DEF;
          adv_en = 1'b1;
          adv_d  = '0;
        end else begin
          ctrl_d = wdata & CTRL_KEEP;
        end
      end else if (regn == PR_ADV) begin
        adv_en = 1'b1;
        adv_d  = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_DEF;
      adv_q  <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (adv_en)  adv_q  <= adv_d;
    end
  end

  always_comb begin
    case (regn)
      PR_CTRL:    rd_val = ctrl_q;
      PR_STAT:    rd_val = STAT_FIXED | (DW'(link_up) << STAT_LINK);
      PR_ID_HI:   rd_val = ID_HI_VAL;
      PR_ID_LO:   rd_val = ID_LO_VAL;
      PR_ADV:     rd_val = adv_q;
      PR_PARTNER: rd_val = PARTNER_VAL;
      default:    rd_val = '0;
    endcase
  end

  // R5
  ctrl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_wr && regn == PR_CTRL && !wdata[CTRL_RST_BIT])
      |=> (ctrl_q[15] == 1'b0 && ctrl_q[9] == 1'b0));
  // R6
  ctrl_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_wr && regn == PR_CTRL && wdata[CTRL_RST_BIT])
      |=> (ctrl_q == 16'h3100 && adv_q == 16'h0000));
  // R9
  adv_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_wr && regn == PR_ADV) |=> (adv_q == $past(wdata)));
  // R11
  unmapped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_wr && regn != PR_CTRL && regn != PR_ADV)
      |=> ($stable(ctrl_q) && $stable(adv_q)));
endmodule

// File: rtl/phy_mgmt_model.sv
module phy_mgmt_model
  import phy_mgmt_pkg::*;
#(
  parameter logic [PAW-1:0] PHY_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          link_up
);
  logic [DW-1:0] cmd_q, cmd_d, data_q, data_d, rd_val;
  logic          pend_q, cmd_we, data_en, hit, exec, exec_wr;
  mgmt_cmd_t     fields;

  phy_cmd_decode #(.PHY_ADDR(PHY_ADDR)) u_dec (
    .cmd_word(cmd_q), .fields(fields), .hit(hit)
  );

  assign exec    = pend_q && hit;
  assign exec_wr = exec && fields.wr;

  phy_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .exec_wr(exec_wr), .regn(fields.regn),
    .wdata(data_q), .link_up(link_up), .rd_val(rd_val)
  );

  always_comb begin
    cmd_we  = bus_wr && !bus_addr;
    cmd_d   = {bus_wdata[DW-1:1], 1'b0};
    data_en = 1'b0;
    data_d  = data_q;
    if (bus_wr && bus_addr) begin
      data_en = 1'b1;
      data_d  = bus_wdata;
    end
    if (exec && !fields.wr) begin
      data_en = 1'b1;
      data_d  = rd_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= cmd_we;
      if (cmd_we)  cmd_q  <= cmd_d;
      if (data_en) data_q <= data_d;
    end
  end

  assign bus_rdata = bus_addr ? data_q : cmd_q;

  // R1
  cmd_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr)
      |=> (cmd_q[0] == 1'b0 && cmd_q[DW-1:1] == $past(bus_wdata[DW-1:1])));
  // R3
  read_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && hit && !fields.wr) |=> (data_q == $past(rd_val)));
  // R2
  foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !hit && !(bus_wr && bus_addr)) |=> $stable(data_q));
  // R12
  host_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr && !(pend_q && hit && !fields.wr))
      |=> (data_q == $past(bus_wdata)));
endmodule

// File: tb/phy_mgmt_model_test.sv
module phy_mgmt_model_test;
  localparam int CLK_P = 10;
  localparam logic [3:0] PHY = 4'h3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_addr = 1'b0, bus_wr = 1'b0, link_up = 1'b1;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int checks = 0, fails = 0;
  string cur_req = "R13";
  bit done = 0;

  // behavioural reference state
  logic [15:0] m_cmd, m_data, m_ctrl, m_adv;
  bit m_pend;

  phy_mgmt_model #(.PHY_ADDR(PHY)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .link_up(link_up)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [15:0] ref_read(input int r, input logic lk);
    case (r)
      0: return m_ctrl;
      1: return 16'hFE28 | (lk ? 16'h0004 : 16'h0000);
      2: return 16'h0044;
      3: return 16'h1400;
      4: return m_adv;
      5: return 16'h0DE0;
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmd = 0; m_data = 0; m_ctrl = 16'h3100; m_adv = 0; m_pend = 0;
    end else begin
      logic [15:0] nd;
      nd = m_data;
      if (bus_wr && bus_addr) nd = bus_wdata;
      if (m_pend && m_cmd[15:12] == PHY) begin
        if (!m_cmd[1]) nd = ref_read(int'(m_cmd[7:4]), link_up);
        else if (m_cmd[7:4] == 4'd0) begin
          if (m_data[15]) begin m_ctrl = 16'h3100; m_adv = 0; end
          else m_ctrl = m_data & ~16'h8200;
        end else if (m_cmd[7:4] == 4'd4) m_adv = m_data;
      end
      m_pend = bus_wr && !bus_addr;
      if (m_pend) m_cmd = {bus_wdata[15:1], 1'b0};
      m_data = nd;
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // apply inputs, let one edge pass, compare the selected window with the model
  task automatic cyc(input logic a, input logic w, input logic [15:0] d);
    bus_addr = a; bus_wr = w; bus_wdata = d;
    @(negedge clk);
    check(cur_req, bus_rdata, a ? m_data : m_cmd);
  endtask

  function automatic logic [15:0] cw(input logic [3:0] p, input logic [3:0] r, input logic w);
    return {p, 4'h0, r, 2'b00, w, 1'b1};
  endfunction

  task automatic phy_read(input logic [3:0] p, input logic [3:0] r, output logic [15:0] v);
    cyc(0, 1, cw(p, r, 1'b0));
    cyc(1, 0, 0);
    v = bus_rdata;
  endtask

  task automatic phy_write(input logic [3:0] p, input logic [3:0] r, input logic [15:0] v);
    cyc(1, 1, v);
    cyc(0, 1, cw(p, r, 1'b1));
    cyc(1, 0, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    @(negedge clk); @(negedge clk);
    // R13 reset state of both windows
    bus_addr = 0; #1 check("R13", bus_rdata, 16'h0000);
    bus_addr = 1; #1 check("R13", bus_rdata, 16'h0000);
    rst_n = 1;
    @(negedge clk);

    cur_req = "R1";
    cyc(0, 1, 16'hABCD);
    check("R1", bus_rdata, 16'hABCC);
    cyc(1, 0, 0);

    cur_req = "R4";
    phy_read(PHY, 4'd0, v); check("R4", v, 16'h3100);
    cur_req = "R3";
    cyc(0, 1, cw(PHY, 4'd3, 1'b0));
    cyc(1, 0, 0); check("R3", bus_rdata, 16'h1400);

    cur_req = "R7";
    link_up = 1; phy_read(PHY, 4'd1, v); check("R7", v, 16'hFE2C);
    link_up = 0; phy_read(PHY, 4'd1, v); check("R7", v, 16'hFE28);
    // link toggles exactly at the executing edge
    cyc(0, 1, cw(PHY, 4'd1, 1'b0));
    link_up = 1; cyc(1, 0, 0); check("R7", bus_rdata, 16'hFE2C);

    cur_req = "R5";
    phy_write(PHY, 4'd0, 16'h7FFF);
    phy_read(PHY, 4'd0, v); check("R5", v, 16'h7DFF);
    phy_write(PHY, 4'd0, 16'h0200);
    phy_read(PHY, 4'd0, v); check("R5", v, 16'h0000);

    cur_req = "R9";
    phy_read(PHY, 4'd4, v); check("R9", v, 16'h0000);
    phy_write(PHY, 4'd4, 16'h05E1);
    phy_read(PHY, 4'd4, v); check("R9", v, 16'h05E1);

    cur_req = "R6";
    phy_write(PHY, 4'd0, 16'h1140);
    cyc(1, 1, 16'h8000);
    cyc(0, 1, cw(PHY, 4'd0, 1'b1));
    link_up = 0; cyc(1, 0, 0);
    phy_read(PHY, 4'd0, v); check("R6", v, 16'h3100);
    phy_read(PHY, 4'd4, v); check("R6", v, 16'h0000);
    phy_read(PHY, 4'd1, v); check("R6", v, 16'hFE28);

    cur_req = "R8";
    phy_write(PHY, 4'd2, 16'hFFFF);
    phy_read(PHY, 4'd2, v); check("R8", v, 16'h0044);
    phy_write(PHY, 4'd3, 16'h0000);
    phy_read(PHY, 4'd3, v); check("R8", v, 16'h1400);

    cur_req = "R10";
    phy_write(PHY, 4'd5, 16'h1234);
    phy_read(PHY, 4'd5, v); check("R10", v, 16'h0DE0);

    cur_req = "R11";
    phy_write(PHY, 4'd9, 16'hBEEF);
    phy_read(PHY, 4'd9, v); check("R11", v, 16'h0000);
    phy_read(PHY, 4'd15, v); check("R11", v, 16'h0000);
    phy_read(PHY, 4'd0, v); check("R11", v, 16'h3100);

    cur_req = "R2";
    cyc(1, 1, 16'h5A5A);
    phy_read(4'h4, 4'd2, v); check("R2", v, 16'h5A5A);
    phy_write(4'h0, 4'd4, 16'h0001);
    phy_read(PHY, 4'd4, v); check("R2", v, 16'h0000);

    cur_req = "R12";
    cyc(1, 1, 16'h0F0F); check("R12", bus_rdata, 16'h0F0F);
    cyc(0, 1, cw(PHY, 4'd2, 1'b0));
    cyc(1, 1, 16'hAAAA); check("R12", bus_rdata, 16'h0044);
    cyc(1, 0, 0);

    for (int i = 0; i < 40; i++) begin
      cur_req = "R3";
      link_up = i[0];
      cyc(0, 1, cw((i % 3 == 0) ? 4'h1 : PHY, 4'(i % 8), i[1]));
      cyc(1, i[2], 16'(i * 16'h0123));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule